// File: doc/BRIEF.md
# Receive Completion Tag Sequencer

This block sits beside a receive descriptor ring and separates "the write index has moved" from "the data behind that slot has arrived". On the producer side, each completed DMA buffer is stamped with the current value of a 13-bit sequence that never takes the value zero. The sequence counts up to 0x1FFF and then starts again at 1. On the consumer side, the block keeps its own copy of the tag it expects next. It compares that copy with the tag read from the descriptor at the head of the ring. The consumer sees a valid entry only when the two agree. A freshly cleared descriptor holds tag zero, so it can never pass as a finished transfer.

The consumer side is a valid/ready sink. `cons_valid` depends only on the ring state, the mode and the descriptor tag, never on `cons_ready`. An entry is taken on a cycle where both are high. The consumer applies back-pressure by holding `cons_ready` low, which leaves everything unchanged. The producer side has no back-pressure: every cycle with `prod_done` high is accepted.

A consume attempt on a non-empty ring whose descriptor tag disagrees takes nothing and leaves the expected tag where it is. It sets a sticky flag and bumps a saturating counter. A mode input turns the tag check off for ring generations that do not need it. In that mode, validity is the ring's non-empty state alone.

Top module: `cpl_tag_sequencer`

## Requirements
- R1: After reset, `prod_tag` and `exp_tag` are both 1, `mism_flag` is 0 and `mism_cnt` is 0.
- R2: `prod_tag` shows the tag for a completion in the same cycle that `prod_done` is high, and advances by one at that clock edge; without `prod_done` it holds.
- R3: Both tag sequences run over 1..0x1FFF: the value after 0x1FFF is 1, and 0 never appears on `prod_tag` or `exp_tag`.
- R4: With `chk_en`=1, `cons_valid` is high exactly when `ring_nonempty`=1 and `desc_tag` equals `exp_tag`.
- R5: A cycle with `cons_valid` and `cons_ready` both high advances `exp_tag` by one, following the R3 sequence.
- R6: With `cons_valid` low, `cons_ready` has no effect on `exp_tag`, and neither does a valid entry left untaken by a low `cons_ready`.
- R7: With `chk_en`=1, a cycle with `ring_nonempty`=1, `cons_ready`=1 and `desc_tag` not equal to `exp_tag` is a mismatch. It sets `mism_flag`, which then stays high until reset, and it leaves `exp_tag` unchanged.
- R8: `mism_cnt` rises by one at each mismatch cycle and saturates at all ones (255 for the default 8-bit width).
- R9: With `chk_en`=0, `cons_valid` equals `ring_nonempty` whatever `desc_tag` holds. No mismatch is recorded, and a consume still advances `exp_tag`.
- R10: With `chk_en`=1, a descriptor tag of 0 never yields `cons_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | 1: tag check on; 0: validity follows ring state only |
| prod_done | input | 1 | Producer completion strobe, one per finished buffer |
| prod_tag | output | 13 | Tag to stamp on the buffer completing this cycle |
| ring_nonempty | input | 1 | Ring holds at least one entry by its indices |
| desc_tag | input | 13 | Tag field of the descriptor at the ring head |
| cons_valid | output | 1 | Head entry is confirmed complete |
| cons_ready | input | 1 | Consumer takes the head entry when valid |
| exp_tag | output | 13 | Tag the consumer expects next |
| mism_flag | output | 1 | Sticky: a mismatch has occurred since reset |
| mism_cnt | output | 8 | Saturating count of mismatch cycles |

## Verification
The assertions assume that every input is stable across the sampling edge and that reset is held for at least one edge before the first checked cycle. They also assume that `desc_tag` is a plain data value, which may be zero or stale, and is never treated as a handshake. The stimulus meets this by changing inputs only on the falling clock edge, after reset has been released. It deliberately feeds zero tags, stale tags and tags that lead the expected tag. It also keeps `cons_ready` high while `cons_valid` is low, so that the back-pressure and mismatch rules are both exercised.

// File: rtl/cts_pkg.sv
package cts_pkg;

  // Outcome of the consumer-side comparison in one cycle.
  typedef enum logic [1:0] {
    DEC_IDLE  = 2'd0,  // nothing attempted, or ring empty
    DEC_TAKE  = 2'd1,  // valid entry taken
    DEC_STALL = 2'd2,  // valid entry present, consumer not ready
    DEC_BAD   = 2'd3   // consume attempt against a wrong tag
  } cons_dec_e;

endpackage

// File: rtl/cts_tag_ctr.sv
module cts_tag_ctr #(
  parameter int TAG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [TAG_W-1:0] tag
);

  localparam logic [TAG_W-1:0] TAG_MAX = {TAG_W{1'b1}};
  localparam logic [TAG_W-1:0] TAG_ONE = TAG_W'(1);

  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] tag_nxt;

  always_comb begin
    tag_nxt = tag_q;
    if (adv) begin
      if (tag_q == TAG_MAX) tag_nxt = TAG_ONE;
      else                  tag_nxt = tag_q + TAG_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tag_q <= TAG_ONE;
    else        tag_q <= tag_nxt;
  end

  assign tag = tag_q;

  p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tag != '0);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && tag == TAG_MAX) |=> tag == TAG_ONE);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && tag != TAG_MAX) |=> tag == $past(tag) + TAG_ONE);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(tag));

endmodule

// File: rtl/cts_judge.sv
module cts_judge
  import cts_pkg::*;
#(
  parameter int TAG_W = 13
) (
  input  logic             chk_en,
  input  logic             ring_nonempty,
  input  logic             cons_ready,
  input  logic [TAG_W-1:0] desc_tag,
  input  logic [TAG_W-1:0] exp_tag,
  output logic             cons_valid,
  output cons_dec_e        dec
);

  logic tag_ok;

  assign tag_ok     = (desc_tag == exp_tag);
  assign cons_valid = ring_nonempty && (!chk_en || tag_ok);

  always_comb begin
    dec = DEC_IDLE;
    if (ring_nonempty) begin
      if (cons_valid && cons_ready)  dec = DEC_TAKE;
      else if (cons_valid)           dec = DEC_STALL;
      else if (cons_ready)           dec = DEC_BAD;
    end
  end

endmodule

// File: rtl/cts_err_ctr.sv
module cts_err_ctr
  import cts_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cons_dec_e        dec,
  output logic             flag,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             hit;
  logic             flag_q;
  logic [CNT_W-1:0] cnt_q;

  assign hit = (dec == DEC_BAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (hit) begin
      flag_q <= 1'b1;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign flag = flag_q;
  assign cnt  = cnt_q;

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> flag);

  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cnt != CNT_MAX) |=> cnt == $past(cnt) + CNT_W'(1));

  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX) |=> cnt == CNT_MAX);

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cnt));

endmodule

// File: rtl/cpl_tag_sequencer.sv
module cpl_tag_sequencer
  import cts_pkg::*;
#(
  parameter int TAG_W = 13,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic             prod_done,
  output logic [TAG_W-1:0] prod_tag,
  input  logic             ring_nonempty,
  input  logic [TAG_W-1:0] desc_tag,
  output logic             cons_valid,
  input  logic             cons_ready,
  output logic [TAG_W-1:0] exp_tag,
  output logic             mism_flag,
  output logic [CNT_W-1:0] mism_cnt
);

  cons_dec_e dec;
  logic      take;

  assign take = (dec == DEC_TAKE);

  cts_tag_ctr #(.TAG_W(TAG_W)) u_prod_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (prod_done),
    .tag   (prod_tag)
  );

  cts_tag_ctr #(.TAG_W(TAG_W)) u_cons_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (take),
    .tag   (exp_tag)
  );

  cts_judge #(.TAG_W(TAG_W)) u_judge (
    .chk_en        (chk_en),
    .ring_nonempty (ring_nonempty),
    .cons_ready    (cons_ready),
    .desc_tag      (desc_tag),
    .exp_tag       (exp_tag),
    .cons_valid    (cons_valid),
    .dec           (dec)
  );

  cts_err_ctr #(.CNT_W(CNT_W)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .dec   (dec),
    .flag  (mism_flag),
    .cnt   (mism_cnt)
  );

  p_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && cons_valid) |-> (desc_tag == exp_tag && ring_nonempty));

  p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && desc_tag == '0) |-> !cons_valid);

  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |-> (cons_valid == ring_nonempty));

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> $stable(mism_cnt));

  p_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_valid && cons_ready) |=> exp_tag != $past(exp_tag));

  p_bad_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && ring_nonempty && cons_ready && desc_tag != exp_tag)
      |=> $stable(exp_tag));

endmodule

// File: tb/cpl_tag_sequencer_bench.sv
module cpl_tag_sequencer_bench;

  localparam int PERIOD  = 10;
  localparam int TAG_MAX = 8191;
  localparam int CNT_MAX = 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_en = 1'b1;
  logic        prod_done = 1'b0;
  logic [12:0] prod_tag;
  logic        ring_nonempty = 1'b0;
  logic [12:0] desc_tag = '0;
  logic        cons_valid;
  logic        cons_ready = 1'b0;
  logic [12:0] exp_tag;
  logic        mism_flag;
  logic [7:0]  mism_cnt;

  int total = 0;
  int bad   = 0;
  int m_prod = 1, m_exp = 1, m_flag = 0, m_cnt = 0;

  always #(PERIOD/2) clk = ~clk;

  cpl_tag_sequencer u_cpl_tag_sequencer (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
    .prod_done(prod_done), .prod_tag(prod_tag),
    .ring_nonempty(ring_nonempty), .desc_tag(desc_tag),
    .cons_valid(cons_valid), .cons_ready(cons_ready),
    .exp_tag(exp_tag), .mism_flag(mism_flag), .mism_cnt(mism_cnt)
  );

  function automatic int nxt(int t);
    return (t == TAG_MAX) ? 1 : t + 1;
  endfunction

  task automatic chk(string rq, string nm, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, nm, act, expv);
    end
  endtask

  // Drive one cycle of stimulus, compare all outputs, then advance the model.
  task automatic step(bit pd, bit en, bit ne, bit rdy, int dt, string rq);
    int  mv;
    bit  mis;
    prod_done = pd; chk_en = en; ring_nonempty = ne;
    cons_ready = rdy; desc_tag = dt[12:0];
    #1;
    mv  = (ne && (!en || dt == m_exp)) ? 1 : 0;
    mis = en && ne && rdy && (dt != m_exp);
    chk(rq, "prod_tag",   int'(prod_tag),   m_prod);
    chk(rq, "exp_tag",    int'(exp_tag),    m_exp);
    chk(rq, "cons_valid", int'(cons_valid), mv);
    chk(rq, "mism_flag",  int'(mism_flag),  m_flag);
    chk(rq, "mism_cnt",   int'(mism_cnt),   m_cnt);
    @(posedge clk);
    if (pd) m_prod = nxt(m_prod);
    if (mv == 1 && rdy) m_exp = nxt(m_exp);
    if (mis) begin
      m_flag = 1;
      if (m_cnt < CNT_MAX) m_cnt++;
    end
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 190000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: state straight out of reset
    step(0, 1, 0, 0, 0, "R1");

    // R2: producer strobes with gaps
    for (int i = 0; i < 12; i++) step(i % 3 != 1, 1, 0, 0, 0, "R2");

    // R4 / R6: matching tag but consumer not ready, entry held
    step(0, 1, 1, 0, m_exp, "R4");
    step(0, 1, 1, 0, m_exp, "R6");
    // R6: ready while ring empty, nothing taken
    step(0, 1, 0, 1, m_exp, "R6");
    // R5: take several matching entries
    for (int i = 0; i < 5; i++) step(0, 1, 1, 1, m_exp, "R5");

    // R4: tag match but ring empty gives no valid
    step(0, 1, 0, 0, m_exp, "R4");
    // R10: cleared descriptor with tag 0, consumer not ready
    step(0, 1, 1, 0, 0, "R10");

    // R7 / R8: stale and early tags with ready high
    step(0, 1, 1, 1, 0, "R7");
    step(0, 1, 1, 1, m_exp + 3, "R7");
    step(0, 1, 1, 0, m_exp, "R7");
    step(0, 1, 1, 1, m_exp - 1, "R8");
    step(0, 1, 1, 1, m_exp, "R5");

    // R9: check off, tags ignored, consume still advances
    step(0, 0, 1, 0, 0, "R9");
    step(0, 0, 1, 1, 0, "R9");
    step(0, 0, 1, 1, 4000, "R9");
    step(0, 0, 0, 1, 0, "R9");

    // R3: run both sequences across the wrap point
    while (m_prod != TAG_MAX - 2) step(1, 1, 0, 0, 0, "R3");
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 0, "R3");
    while (m_exp != TAG_MAX - 2) step(0, 1, 1, 1, m_exp, "R3");
    for (int i = 0; i < 6; i++) step(i % 2 == 0, 1, 1, 1, m_exp, "R3");

    // R8: saturation of the mismatch counter
    for (int i = 0; i < 260; i++) step(0, 1, 1, 1, 0, "R8");
    step(0, 1, 1, 0, m_exp, "R7");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule